// File: doc/BRIEF.md
# Wave Initial Scalar Register Loader

This block runs once for every wavefront launch. It produces the ordered list of scalar-register writes that seed the wave before it starts. A start pulse captures an enable word, the dispatch-wide values and the values for this wave. The block then walks a fixed catalogue of candidate register words and emits one write per clock to a simple register-file write port. Each write carries a register index and a 32-bit data word.

The first group of words is the user group. Its items are switched on by the low ten bits of the enable word. Enabled items are packed densely from register 0. At most 16 user words are written, and any further words are dropped. The system words follow directly after the last user word, and each has its own enable. Two kinds of word are computed on the fly. Each grid work-group count is a ceiling division of grid size by work-group size. The per-item scratch size is rounded up to a whole dword. The work-group info word is packed from three fields.

Top module: `wave_sreg_loader`

## Requirements
- R1: User items are taken in this order of enable bits: bit 0 segment buffer descriptor (4 words, `seg_buf[31:0]` first), bit 1 dispatch pointer, bit 2 queue pointer, bit 3 kernel-argument pointer, bit 4 dispatch ID (2 words each, low half first), bit 5 scratch setup (2 words), bit 6 scratch size, bits 7/8/9 work-group counts X/Y/Z (1 word each). Enabled words take indices 0,1,2,... densely, and disabled items take none.
- R2: No more than 16 user words are written. Words past the 16th are dropped, and `user_cnt` equals the minimum of the requested word total and 16.
- R3: Enable bits 15:10 have no effect on the write stream or on `user_cnt`.
- R4: The work-group count word for each dimension is ceil(grid/wgsize), computed exactly without overflow. A work-group size of zero gives a count of zero.
- R5: The scratch setup item writes `scratch_base` first, then the byte size rounded up to a multiple of 4 (modulo 2^32). The scratch size item writes that same rounded value.
- R6: System words follow the last user word in this order: work-group ID X, Y, Z (enabled by `en_wgid[0]`, `[1]`, `[2]`), then the info word (`en_info`), then the wave scratch offset (`en_wave_off`). Each enabled word takes the next index.
- R7: The info word holds `first_wave` in bit 31, zeros in bits 30:17, `oa_term` in bits 16:6 and `tg_waves` in bits 5:0.
- R8: Writes start one cycle after the start cycle and follow on consecutive cycles. `done` is a one-cycle pulse in the cycle after the last write, which is the cycle after start when nothing is enabled. `wr_vld` and `done` are never high together.
- R9: `user_cnt` takes its new value in the cycle `done` is high and holds it until the next `done`.
- R10: A start pulse received while a launch is in progress is ignored, and the stream in progress keeps the values captured at its own start.
- R11: After reset, `wr_vld`, `done` and `user_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse; captures all inputs below |
| en_user | input | 16 | User item enables (bits 15:10 ignored) |
| en_wgid | input | 3 | Work-group ID X/Y/Z enables |
| en_info | input | 1 | Work-group info word enable |
| en_wave_off | input | 1 | Wave scratch offset enable |
| seg_buf | input | 128 | Segment buffer descriptor |
| disp_ptr | input | 64 | Dispatch packet address |
| queue_ptr | input | 64 | Queue object address |
| karg_ptr | input | 64 | Kernel argument block address |
| disp_id | input | 64 | Dispatch identifier |
| scratch_base | input | 32 | Scratch base offset for the dispatch |
| priv_bytes | input | 32 | Per-item scratch byte size |
| grid_x | input | 32 | Grid size X |
| grid_y | input | 32 | Grid size Y |
| grid_z | input | 32 | Grid size Z |
| wg_size_x | input | 32 | Work-group size X |
| wg_size_y | input | 32 | Work-group size Y |
| wg_size_z | input | 32 | Work-group size Z |
| wg_id_x | input | 32 | Work-group ID X of this wave |
| wg_id_y | input | 32 | Work-group ID Y of this wave |
| wg_id_z | input | 32 | Work-group ID Z of this wave |
| first_wave | input | 1 | First wave of its work-group |
| oa_term | input | 11 | Ordered-append term |
| tg_waves | input | 6 | Work-group size in waves |
| wave_off | input | 32 | Wave scratch byte offset |
| wr_vld | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register index of the write |
| wr_data | output | 32 | Register write data |
| done | output | 1 | Launch sequence complete pulse |
| user_cnt | output | 5 | Number of user words written |

## Verification
The inputs are captured at the start edge. The k-th write (counting from zero) is then due at the k+1-th clock edge after that, and `done` with `user_cnt` is due at the edge after the last write. The bench drives at the falling edge and samples at each following falling edge. It counts cycles from the start edge and requires write k and the `done` pulse to land on exactly those counts. It then samples once more to confirm that `done` has dropped and `user_cnt` has held.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  localparam int DW         = 32;
  localparam int EN_W       = 16;
  localparam int N_UITEMS   = 10;
  localparam int USER_WORDS = 18;
  localparam int SYS_WORDS  = 5;
  localparam int N_SLOTS    = USER_WORDS + SYS_WORDS;

  typedef logic [DW-1:0] word_t;

  // words occupied by each user item, in enable-bit order
  function automatic int item_words(input int i);
    case (i)
      0:             return 4;
      1, 2, 3, 4, 5: return 2;
      default:       return 1;
    endcase
  endfunction

  // user item owning a given user slot
  function automatic int slot_item(input int s);
    int acc;
    acc = 0;
    for (int i = 0; i < N_UITEMS; i++) begin
      if (s < acc + item_words(i)) return i;
      acc += item_words(i);
    end
    return N_UITEMS - 1;
  endfunction

  typedef struct packed {
    logic [EN_W-1:0]     en_user;
    logic [SYS_WORDS-1:0] en_sys;   // {wave_off, info, id_z, id_y, id_x}
    logic [4*DW-1:0]     seg_buf;
    logic [2*DW-1:0]     disp_ptr;
    logic [2*DW-1:0]     queue_ptr;
    logic [2*DW-1:0]     karg_ptr;
    logic [2*DW-1:0]     disp_id;
    word_t               scratch_base;
    word_t               priv_bytes;
    logic [2:0][DW-1:0]  grid;
    logic [2:0][DW-1:0]  wgsz;
    logic [2:0][DW-1:0]  wgid;
    logic                first_wave;
    logic [10:0]         oa_term;
    logic [5:0]          tg_waves;
    word_t               wave_off;
  } launch_t;
endpackage

// File: rtl/wsl_ceil_div.sv
module wsl_ceil_div #(
  parameter int W = 32
) (
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo
);
  logic [W:0] sum;
  logic [W:0] q_wide;

  always_comb begin
    sum    = {1'b0, num} + {1'b0, den} - {{W{1'b0}}, 1'b1};
    q_wide = '0;
    if (den != '0) q_wide = sum / {1'b0, den};
    quo    = q_wide[W-1:0];
  end
endmodule

// File: rtl/wsl_slot_map.sv
module wsl_slot_map
  import wsl_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int CNT_W   = $clog2(USER_CAP + 1)
) (
  input  launch_t                   lq,
  input  logic [2:0][DW-1:0]        wg_cnt,
  output logic [N_SLOTS-1:0]        slot_en,
  output logic [N_SLOTS-1:0][DW-1:0] slot_data,
  output logic [CNT_W-1:0]          user_cnt
);
  word_t rnd_bytes;
  word_t info_word;
  int    taken;

  assign rnd_bytes = (lq.priv_bytes + 32'd3) & ~32'd3;
  assign info_word = {lq.first_wave, 14'd0, lq.oa_term, lq.tg_waves};

  // user enables with the cap applied from the front of the order
  always_comb begin
    taken = 0;
    for (int s = 0; s < USER_WORDS; s++) begin
      slot_en[s] = lq.en_user[slot_item(s)] && (taken < USER_CAP);
      if (slot_en[s]) taken = taken + 1;
    end
    for (int k = 0; k < SYS_WORDS; k++) slot_en[USER_WORDS+k] = lq.en_sys[k];
    user_cnt = CNT_W'(taken);
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_seg
      assign slot_data[g] = lq.seg_buf[g*DW +: DW];
    end
    for (g = 0; g < 2; g++) begin : g_ptr
      assign slot_data[4+g]  = lq.disp_ptr[g*DW +: DW];
      assign slot_data[6+g]  = lq.queue_ptr[g*DW +: DW];
      assign slot_data[8+g]  = lq.karg_ptr[g*DW +: DW];
      assign slot_data[10+g] = lq.disp_id[g*DW +: DW];
    end
    for (g = 0; g < 3; g++) begin : g_dim
      assign slot_data[15+g]         = wg_cnt[g];
      assign slot_data[USER_WORDS+g] = lq.wgid[g];
    end
  endgenerate

  assign slot_data[12]           = lq.scratch_base;
  assign slot_data[13]           = rnd_bytes;
  assign slot_data[14]           = rnd_bytes;
  assign slot_data[USER_WORDS+3] = info_word;
  assign slot_data[USER_WORDS+4] = lq.wave_off;
endmodule

// File: rtl/wsl_seq.sv
module wsl_seq
  import wsl_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int CNT_W   = $clog2(USER_CAP + 1),
  localparam int IDX_W   = $clog2(USER_CAP + SYS_WORDS),
  localparam int PTR_W   = $clog2(N_SLOTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [N_SLOTS-1:0]        slot_en,
  input  logic [N_SLOTS-1:0][DW-1:0] slot_data,
  input  logic [CNT_W-1:0]          cnt_in,
  output logic                      busy,
  output logic                      wr_vld,
  output logic [IDX_W-1:0]          wr_idx,
  output word_t                     wr_data,
  output logic                      done,
  output logic [CNT_W-1:0]          user_cnt
);
  logic [PTR_W-1:0] ptr_q, ptr_n, nxt;
  logic [IDX_W-1:0] idx_q, idx_n, widx_n;
  logic             busy_n, vld_n, done_n, found;
  word_t            wdata_n;
  logic [CNT_W-1:0] ucnt_n;

  // lowest enabled slot at or above the pointer
  always_comb begin
    found = 1'b0;
    nxt   = '0;
    for (int s = 0; s < N_SLOTS; s++) begin
      if (!found && slot_en[s] && (PTR_W'(s) >= ptr_q)) begin
        found = 1'b1;
        nxt   = PTR_W'(s);
      end
    end
  end

  always_comb begin
    busy_n  = busy;
    ptr_n   = ptr_q;
    idx_n   = idx_q;
    vld_n   = 1'b0;
    done_n  = 1'b0;
    widx_n  = wr_idx;
    wdata_n = wr_data;
    ucnt_n  = user_cnt;
    if (go) begin
      busy_n = 1'b1;
      ptr_n  = '0;
      idx_n  = '0;
    end else if (busy) begin
      if (found) begin
        vld_n   = 1'b1;
        widx_n  = idx_q;
        wdata_n = slot_data[nxt];
        ptr_n   = nxt + 1'b1;
        idx_n   = idx_q + 1'b1;
      end else begin
        busy_n = 1'b0;
        done_n = 1'b1;
        ucnt_n = cnt_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ptr_q    <= '0;
      idx_q    <= '0;
      wr_vld   <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
      done     <= 1'b0;
      user_cnt <= '0;
    end else begin
      busy     <= busy_n;
      ptr_q    <= ptr_n;
      idx_q    <= idx_n;
      wr_vld   <= vld_n;
      wr_idx   <= widx_n;
      wr_data  <= wdata_n;
      done     <= done_n;
      user_cnt <= ucnt_n;
    end
  end
endmodule

// File: rtl/wave_sreg_loader.sv
module wave_sreg_loader
  import wsl_pkg::*;
#(
  parameter int USER_CAP = 16,
  localparam int IDX_W   = $clog2(USER_CAP + SYS_WORDS),
  localparam int CNT_W   = $clog2(USER_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EN_W-1:0]   en_user,
  input  logic [2:0]        en_wgid,
  input  logic              en_info,
  input  logic              en_wave_off,
  input  logic [4*DW-1:0]   seg_buf,
  input  logic [2*DW-1:0]   disp_ptr,
  input  logic [2*DW-1:0]   queue_ptr,
  input  logic [2*DW-1:0]   karg_ptr,
  input  logic [2*DW-1:0]   disp_id,
  input  logic [DW-1:0]     scratch_base,
  input  logic [DW-1:0]     priv_bytes,
  input  logic [DW-1:0]     grid_x,
  input  logic [DW-1:0]     grid_y,
  input  logic [DW-1:0]     grid_z,
  input  logic [DW-1:0]     wg_size_x,
  input  logic [DW-1:0]     wg_size_y,
  input  logic [DW-1:0]     wg_size_z,
  input  logic [DW-1:0]     wg_id_x,
  input  logic [DW-1:0]     wg_id_y,
  input  logic [DW-1:0]     wg_id_z,
  input  logic              first_wave,
  input  logic [10:0]       oa_term,
  input  logic [5:0]        tg_waves,
  input  logic [DW-1:0]     wave_off,
  output logic              wr_vld,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DW-1:0]     wr_data,
  output logic              done,
  output logic [CNT_W-1:0]  user_cnt
);
  logic [1:0]                rst_sync;
  logic                      rst_int_n;
  logic                      busy, go;
  launch_t                   lq, lq_n;
  logic [2:0][DW-1:0]        wg_cnt;
  logic [N_SLOTS-1:0]        slot_en;
  logic [N_SLOTS-1:0][DW-1:0] slot_data;
  logic [CNT_W-1:0]          cnt_calc;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign go = start & ~busy;

  always_comb begin
    lq_n.en_user      = en_user;
    lq_n.en_sys       = {en_wave_off, en_info, en_wgid};
    lq_n.seg_buf      = seg_buf;
    lq_n.disp_ptr     = disp_ptr;
    lq_n.queue_ptr    = queue_ptr;
    lq_n.karg_ptr     = karg_ptr;
    lq_n.disp_id      = disp_id;
    lq_n.scratch_base = scratch_base;
    lq_n.priv_bytes   = priv_bytes;
    lq_n.grid         = {grid_z, grid_y, grid_x};
    lq_n.wgsz         = {wg_size_z, wg_size_y, wg_size_x};
    lq_n.wgid         = {wg_id_z, wg_id_y, wg_id_x};
    lq_n.first_wave   = first_wave;
    lq_n.oa_term      = oa_term;
    lq_n.tg_waves     = tg_waves;
    lq_n.wave_off     = wave_off;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lq <= '0;
    else if (go)    lq <= lq_n;
  end

  genvar d;
  generate
    for (d = 0; d < 3; d++) begin : g_div
      wsl_ceil_div #(.W(DW)) u_div (
        .num (lq.grid[d]),
        .den (lq.wgsz[d]),
        .quo (wg_cnt[d])
      );
    end
  endgenerate

  wsl_slot_map #(.USER_CAP(USER_CAP)) u_map (
    .lq        (lq),
    .wg_cnt    (wg_cnt),
    .slot_en   (slot_en),
    .slot_data (slot_data),
    .user_cnt  (cnt_calc)
  );

  wsl_seq #(.USER_CAP(USER_CAP)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (go),
    .slot_en   (slot_en),
    .slot_data (slot_data),
    .cnt_in    (cnt_calc),
    .busy      (busy),
    .wr_vld    (wr_vld),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .done      (done),
    .user_cnt  (user_cnt)
  );
endmodule

// File: rtl/wsl_chk.sv
module wsl_chk #(
  parameter int USER_CAP = 16,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_vld,
  input logic [IDX_W-1:0] wr_idx,
  input logic             done,
  input logic [CNT_W-1:0] user_cnt
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  vld_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && done));
  // R1
  first_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_vld) |-> wr_idx == '0);
  // R1
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && $past(wr_vld)) |-> wr_idx == IDX_W'($past(wr_idx) + 1'b1));
  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> user_cnt <= CNT_W'(USER_CAP));
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(user_cnt));
endmodule

bind wave_sreg_loader wsl_chk #(
  .USER_CAP (USER_CAP),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_vld   (wr_vld),
  .wr_idx   (wr_idx),
  .done     (done),
  .user_cnt (user_cnt)
);

// File: tb/wave_sreg_loader_bench.sv
module wave_sreg_loader_bench;
  localparam int USER_CAP = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [15:0] en_user;
  logic [2:0]  en_wgid;
  logic        en_info, en_wave_off;
  logic [31:0] seg [4];
  logic [31:0] dp [2], qp [2], kp [2], di [2];
  logic [31:0] scratch_base, priv_bytes;
  logic [31:0] grid [3], wgs [3], wid [3];
  logic        first_wave;
  logic [10:0] oa_term;
  logic [5:0]  tg_waves;
  logic [31:0] wave_off;
  logic        wr_vld, done;
  logic [4:0]  wr_idx, user_cnt;
  logic [31:0] wr_data;

  int          n_vec = 0, n_bad = 0;
  logic [31:0] exp_data [32];
  string       exp_tag [32];
  int          n_exp, exp_ucnt;
  logic [31:0] seed = 32'h1234_5678;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  wave_sreg_loader #(.USER_CAP(USER_CAP)) u_wave_sreg_loader (
    .clk(clk), .rst_n(rst_n), .start(start), .en_user(en_user),
    .en_wgid(en_wgid), .en_info(en_info), .en_wave_off(en_wave_off),
    .seg_buf({seg[3], seg[2], seg[1], seg[0]}),
    .disp_ptr({dp[1], dp[0]}), .queue_ptr({qp[1], qp[0]}),
    .karg_ptr({kp[1], kp[0]}), .disp_id({di[1], di[0]}),
    .scratch_base(scratch_base), .priv_bytes(priv_bytes),
    .grid_x(grid[0]), .grid_y(grid[1]), .grid_z(grid[2]),
    .wg_size_x(wgs[0]), .wg_size_y(wgs[1]), .wg_size_z(wgs[2]),
    .wg_id_x(wid[0]), .wg_id_y(wid[1]), .wg_id_z(wid[2]),
    .first_wave(first_wave), .oa_term(oa_term), .tg_waves(tg_waves),
    .wave_off(wave_off),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_data(wr_data),
    .done(done), .user_cnt(user_cnt)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] nxt_rand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  function automatic logic [31:0] ceil_ref(input logic [31:0] g, input logic [31:0] w);
    logic [63:0] s;
    if (w == 32'd0) return 32'd0;
    s = {32'd0, g} + {32'd0, w} - 64'd1;
    return 32'(s / {32'd0, w});
  endfunction

  function automatic int isize(input int i);
    if (i == 0) return 4;
    if (i <= 5) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] uword(input int i, input int w);
    logic [31:0] rnd;
    rnd = (priv_bytes + 32'd3) & 32'hFFFF_FFFC;
    case (i)
      0: return seg[w];
      1: return dp[w];
      2: return qp[w];
      3: return kp[w];
      4: return di[w];
      5: return (w == 0) ? scratch_base : rnd;
      6: return rnd;
      default: return ceil_ref(grid[i-7], wgs[i-7]);
    endcase
  endfunction

  function automatic string utag(input int i);
    if (i == 5 || i == 6) return "R5";
    if (i >= 7) return "R4";
    return "R1";
  endfunction

  task automatic push(input logic [31:0] v, input string t);
    if (n_exp < 32) begin
      exp_data[n_exp] = v;
      exp_tag[n_exp]  = t;
    end
    n_exp++;
  endtask

  task automatic build_expected();
    int ucnt;
    n_exp = 0;
    ucnt  = 0;
    for (int i = 0; i < 10; i++)
      if (en_user[i])
        for (int w = 0; w < isize(i); w++)
          if (ucnt < USER_CAP) begin
            push(uword(i, w), (ucnt >= 13) ? "R2" : utag(i));
            ucnt++;
          end
    exp_ucnt = ucnt;
    for (int k = 0; k < 3; k++)
      if (en_wgid[k]) push(wid[k], "R6");
    if (en_info) push({first_wave, 14'd0, oa_term, tg_waves}, "R7");
    if (en_wave_off) push(wave_off, "R6");
  endtask

  task automatic set_data(input int r);
    logic [31:0] cg [8];
    logic [31:0] cw [8];
    logic [31:0] pb [6];
    cg = '{32'd0, 32'd7, 32'd10, 32'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'd100};
    cw = '{32'd5, 32'd0, 32'd10, 32'd10, 32'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd7};
    pb = '{32'd0, 32'd1, 32'd3, 32'd4, 32'd5, 32'hFFFF_FFFE};
    for (int k = 0; k < 4; k++) seg[k] = nxt_rand();
    for (int k = 0; k < 2; k++) begin
      dp[k] = nxt_rand(); qp[k] = nxt_rand(); kp[k] = nxt_rand(); di[k] = nxt_rand();
    end
    scratch_base = nxt_rand();
    priv_bytes   = pb[r % 6];
    grid[0] = cg[r % 8];       wgs[0] = cw[r % 8];
    grid[1] = cg[(r + 3) % 8]; wgs[1] = cw[(r + 3) % 8];
    grid[2] = cg[(r + 5) % 8]; wgs[2] = cw[(r + 5) % 8];
    for (int k = 0; k < 3; k++) wid[k] = nxt_rand();
    first_wave = seed[3];
    oa_term    = seed[20:10];
    tg_waves   = seed[29:24];
    wave_off   = nxt_rand();
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic launch(input logic [15:0] um, input logic [4:0] se,
                        input bit poke, input string xtag);
    int cyc, k;
    string t;
    en_user = um;
    {en_wave_off, en_info, en_wgid} = se;
    build_expected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    k   = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 2) begin
        start   = 1'b1;
        en_user = ~um;
        en_wgid = ~se[2:0];
      end else if (poke && cyc == 3) begin
        start = 1'b0;
      end
      if (wr_vld) begin
        t = (xtag != "") ? xtag : ((k < n_exp) ? exp_tag[k] : "R2");
        check(k < n_exp && wr_idx == 5'(k), t, "write index", {27'd0, wr_idx}, k);
        check(k < n_exp && wr_data == exp_data[k], t, "write data", wr_data,
              (k < n_exp) ? exp_data[k] : 32'hDEAD_DEAD);
        k++;
      end
      if (wr_vld && done) check(1'b0, "R8", "vld with done", 1, 0);
      if (done) begin
        check(cyc == n_exp + 1, "R8", "done cycle", cyc, n_exp + 1);
        check(k == n_exp, (xtag != "") ? xtag : "R1", "write count", k, n_exp);
        check(user_cnt == 5'(exp_ucnt), (xtag != "") ? xtag : "R2", "user count",
              {27'd0, user_cnt}, exp_ucnt);
        break;
      end
      if (cyc > 40) begin
        check(1'b0, "R8", "done missing", cyc, n_exp + 1);
        break;
      end
    end
    @(negedge clk);
    // R9 hold, R8 single pulse
    check(!done && user_cnt == 5'(exp_ucnt), "R9", "count hold after done",
          {26'd0, done, user_cnt}, exp_ucnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R8 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    en_user = '0;
    en_wgid = '0;
    en_info = 1'b0;
    en_wave_off = 1'b0;
    set_data(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!wr_vld && !done && user_cnt == 5'd0, "R11", "reset outputs",
          {25'd0, wr_vld, done, user_cnt}, 32'd0);

    // R1 R2 R4 R5 R6 R7: every user enable combination; R3: reserved bits set
    for (int m = 0; m < 1024; m++) begin
      set_data(m);
      launch({6'(m), 10'(m)}, 5'(m[4:0] ^ m[9:5]), 1'b0, "");
    end
    // R6: every system combination with full and empty user groups
    for (int s = 0; s < 32; s++) begin
      set_data(s + 7);
      launch(16'h03FF, 5'(s), 1'b0, "");
      set_data(s + 11);
      launch(16'h0000, 5'(s), 1'b0, "");
    end
    // R3: only reserved bits set -> no user words
    set_data(3);
    launch(16'hFC00, 5'b00000, 1'b0, "R3");
    set_data(4);
    launch(16'hFC00, 5'b10101, 1'b0, "R3");
    // R10: start during a launch is ignored
    set_data(5);
    launch(16'h03FF, 5'b11111, 1'b1, "R10");
    set_data(6);
    launch(16'h0155, 5'b01010, 1'b0, "");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule